// File: doc/BRIEF.md
# Scan Register Bank with Output Hold

This block is a bank of WIDTH storage bits, each built as a multiplexed-input scan flip-flop followed by an output-hold stage. When test enable is low, every bit loads its parallel data input, and the bank acts as a plain pipeline register. When test enable is high, the bits form one serial chain: the scan input enters bit 0, each bit passes its stored value to the next one up, and bit WIDTH-1 drives the scan output.

A separate hold control freezes the parallel output bus at its last value. The internal chain keeps shifting from its own stored state while the output is held, so a pattern can be shifted in or out without any toggling on the logic that reads the bus. Holding in this way reduces switching power and keeps that logic isolated from scan activity. When the hold control is released, the output bus takes the internal contents on the same edge that updates them.

Top module: `scan_hold_bank`

## Requirements
- R1: A synchronous active-high reset clears every internal bit and the held output. After the edge, `dout` and `scan_out` are zero, and the hold control has no effect on this.
- R2: With `test_en` = 0 and `hold` = 0, `dout` equals the `din` value that was sampled on the previous rising edge (one cycle of latency).
- R3: With `test_en` = 1, each edge loads `scan_in` into bit 0 and the previous value of bit i-1 into bit i. `scan_out` is bit WIDTH-1.
- R4: While `hold` = 1 at an edge, `dout` keeps its previous value after that edge, for both values of `test_en` and for any `din` or `scan_in`.
- R5: Shifting continues from the internal state while `hold` = 1, so `scan_out` follows the chain contents during a held shift.
- R6: On the first edge where `hold` = 0 after a held period, `dout` takes the internal contents as updated by that same edge.
- R7: Loading a WIDTH-bit pattern P takes exactly WIDTH shift edges when P[WIDTH-1-k] is presented at shift k (k = 0 first). Afterwards the bank holds P, and the first bit presented sits in bit WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | 0: capture `din`; 1: serial shift |
| hold | input | 1 | 1: freeze `dout` at its last value |
| din | input | WIDTH | Parallel functional data |
| scan_in | input | 1 | Serial input to bit 0 |
| dout | output | WIDTH | Held parallel output |
| scan_out | output | 1 | Serial output from bit WIDTH-1 |

## Verification
The properties assume that every control input is a clean 0 or 1 at each rising edge, and that reset lasts at least one edge before the bank is used. They also assume that WIDTH is at least 2, so that a neighbouring bit exists for the shift check. The stimulus changes inputs only one time unit after each rising edge, holds reset for several edges at the start, and drives known values on `din` and `scan_in` in every cycle, including the cycles in which those inputs are expected to be ignored.

// File: rtl/shb_pkg.sv
package shb_pkg;

    typedef enum logic {
        CAP_FUNC = 1'b0,
        CAP_SCAN = 1'b1
    } cap_sel_e;

endpackage

// File: rtl/shb_chain.sv
module shb_chain
    import shb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cap_sel_e         sel,
    input  logic [WIDTH-1:0] din,
    input  logic             si,
    output logic [WIDTH-1:0] core_q,
    output logic [WIDTH-1:0] core_d
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;
    logic [WIDTH-1:0] pick;

    // one 2:1 selector per cell; cell 0 takes the serial input
    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        if (g == 0) begin : g_head
            assign pick[g] = (sel == CAP_SCAN) ? si : din[g];
        end else begin : g_body
            assign pick[g] = (sel == CAP_SCAN) ? st_q.bits[g-1] : din[g];
        end
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else begin
            st_d.bits = pick;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign core_q = st_q.bits;
    assign core_d = st_d.bits;

endmodule

// File: rtl/shb_hold.sv
module shb_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [WIDTH-1:0] upd,
    output logic [WIDTH-1:0] shown
);

    typedef struct packed {
        logic [WIDTH-1:0] vis;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.vis = '0;
        end else if (!hold) begin
            st_d.vis = upd;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign shown = st_q.vis;

endmodule

// File: rtl/scan_hold_bank.sv
module scan_hold_bank
    import shb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_en,
    input  logic             hold,
    input  logic [WIDTH-1:0] din,
    input  logic             scan_in,
    output logic [WIDTH-1:0] dout,
    output logic             scan_out
);

    localparam int LAST = WIDTH - 1;

    cap_sel_e         sel;
    logic [WIDTH-1:0] core_q;
    logic [WIDTH-1:0] core_d;

    assign sel = test_en ? CAP_SCAN : CAP_FUNC;

    shb_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .din    (din),
        .si     (scan_in),
        .core_q (core_q),
        .core_d (core_d)
    );

    shb_hold #(.WIDTH(WIDTH)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .upd   (core_d),
        .shown (dout)
    );

    assign scan_out = core_q[LAST];

endmodule

// File: rtl/shb_checker.sv
module shb_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             test_en,
    input logic             hold,
    input logic [WIDTH-1:0] din,
    input logic             scan_in,
    input logic [WIDTH-1:0] dout,
    input logic             scan_out,
    input logic [WIDTH-1:0] core_q
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dout == '0) && (scan_out == 1'b0));

    a_r2_func_capture: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !hold) |=> dout == $past(din));

    a_r3_shift_head: assert property (@(posedge clk) disable iff (rst)
        test_en |=> core_q[0] == $past(scan_in));

    a_r3_shift_body: assert property (@(posedge clk) disable iff (rst)
        test_en |=> core_q[WIDTH-1:1] == $past(core_q[WIDTH-2:0]));

    a_r4_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(dout));

    a_r5_shift_under_hold: assert property (@(posedge clk) disable iff (rst)
        (hold && test_en) |=> scan_out == $past(core_q[WIDTH-2]));

    a_r6_release_tracks: assert property (@(posedge clk) disable iff (rst)
        !hold |=> dout == core_q);

endmodule

bind scan_hold_bank shb_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .test_en  (test_en),
    .hold     (hold),
    .din      (din),
    .scan_in  (scan_in),
    .dout     (dout),
    .scan_out (scan_out),
    .core_q   (core_q)
);

// File: tb/scan_hold_bank_test.sv
`timescale 1ns/1ps
module scan_hold_bank_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         test_en = 1'b0;
    logic         hold = 1'b0;
    logic [W-1:0] din = '1;
    logic         scan_in = 1'b1;
    logic [W-1:0] dout;
    logic         scan_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    scan_hold_bank #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .test_en  (test_en),
        .hold     (hold),
        .din      (din),
        .scan_in  (scan_in),
        .dout     (dout),
        .scan_out (scan_out)
    );

    always #2.5 clk = ~clk;

    // advance one edge, then settle away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_func(input logic [W-1:0] v);
        test_en = 1'b0; hold = 1'b0; din = v;
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; hold = 1'b1; test_en = 1'b1; din = 8'hC3; scan_in = 1'b1;
        tick(); tick();
        check("R1 dout", dout, '0);
        check("R1 scan_out", {{(W-1){1'b0}}, scan_out}, '0);
        rst = 1'b0; hold = 1'b0; test_en = 1'b0;
    endtask

    task automatic t_func();
        logic [W-1:0] pats [5] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81};
        foreach (pats[i]) begin
            load_func(pats[i]);
            check("R2 capture", dout, pats[i]);
        end
    endtask

    // shift P in; dout visible (hold low), previous contents zero
    task automatic t_shift(input logic [W-1:0] p);
        load_func('0);
        test_en = 1'b1; hold = 1'b0;
        for (int j = 0; j < W; j++) begin
            scan_in = p[W-1-j];
            tick();
            check("R3 scan_out", {{(W-1){1'b0}}, scan_out},
                  {{(W-1){1'b0}}, (j == W-1) ? p[W-1] : 1'b0});
        end
        check("R7 loaded pattern", dout, p);
        // unload: the first bit out is the first bit in
        for (int j = 0; j < W; j++) begin
            scan_in = 1'b0;
            check("R3 unload order", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, p[W-1-j]});
            tick();
        end
        check("R3 chain drained", dout, '0);
    endtask

    task automatic t_hold(input logic [W-1:0] h, input logic [W-1:0] q);
        logic expb;
        load_func(h);
        check("R2 preload", dout, h);
        hold = 1'b1; test_en = 1'b1;
        for (int j = 0; j < W; j++) begin
            scan_in = q[W-1-j];
            din = ~din;
            tick();
            check("R4 frozen during shift", dout, h);
            expb = (j < W-1) ? h[W-2-j] : q[W-1];
            check("R5 scan_out under hold", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, expb});
        end
        // functional mode with hold: the bus stays frozen
        test_en = 1'b0; din = 8'h77;
        tick();
        check("R4 frozen during capture", dout, h);
        // release while shifting one more bit: bus shows updated core
        test_en = 1'b1; scan_in = 1'b1; hold = 1'b0;
        din = 8'h12;
        tick();
        check("R6 release", dout, {8'h77} << 1 | 8'h01);
    endtask

    task automatic t_hold_reset();
        load_func(8'h9E);
        hold = 1'b1;
        rst = 1'b1;
        tick();
        check("R1 reset under hold", dout, '0);
        rst = 1'b0; hold = 1'b0;
    endtask

    initial begin
        #1;
        t_reset();
        t_func();
        t_shift(8'b1101_0010);
        t_shift(8'b0110_1001);
        t_hold(8'h5A, 8'hC6);
        t_hold(8'h0F, 8'h93);
        t_hold_reset();
        t_func();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule